// File: doc/BRIEF.md
# Rank-Clustering Request Queue Reorderer

This block is a small request queue for a memory controller. Each pending command carries a target rank, a read/write flag and an address. Commands are appended at the tail through an enqueue handshake and leave from the head through a dequeue handshake. Pulsing the cluster strobe starts a regrouping pass. The pass rearranges the stored commands in place so that all commands for one rank become contiguous. It is a stable grouping. The set for the rank of the oldest command comes first. The next set belongs to the rank of the oldest command not yet placed, and so on. Inside each set, commands keep their arrival order.

The pass visits one queue slot per clock cycle. Each rank owns an end-of-set marker that starts out unassigned. The first command seen for a rank assigns that rank's marker to the slot just past it. A later command for an already-marked rank is moved into the slot its marker names. The commands between that slot and its old position shift one place toward the tail. Every other marker that lies beyond the insertion point moves up by one, and so does the rank's own marker.

Per-rank read, write and total counts are reported at all times. Per-rank set end positions are reported once a pass has finished. A downstream policy can combine the counts and set boundaries to decide which sets to release. That policy is not part of this block.

The controller has three states:
- `RCQ_IDLE`: the queue accepts enqueue and dequeue traffic.
- `RCQ_SCAN`: one slot is regrouped per cycle.
- `RCQ_DONE`: a single cycle that raises the completion flag.

The transitions are:
- IDLE→SCAN when the strobe arrives and the queue holds entries.
- IDLE→DONE when the strobe arrives and the queue is empty.
- SCAN→SCAN while slots remain to be visited.
- SCAN→DONE after the last occupied slot is visited.
- DONE→IDLE unconditionally.

Top module: `rank_cluster_rq`

## Requirements
- R1: After reset the queue is empty:
  - `enq_ready` is 1.
  - `deq_valid` is 0.
  - `clus_done` is 0.
  - Every per-rank count is 0.
  - Every `set_vld` bit is 0.
- R2: Outside a pass, an accepted command is appended at the tail. Dequeue returns commands oldest first. With DEPTH entries stored, `enq_ready` is 0.
- R3: A strobe accepted in IDLE with N stored entries raises `clus_done` for exactly one cycle. This happens in the (N+1)-th cycle after the accepting edge when N>0, and in the first cycle when N=0.
- R4: From the accepting edge through the `clus_done` cycle, `enq_ready` and `deq_valid` are 0, and further strobes are ignored. The block is back in IDLE in the cycle after `clus_done`.
- R5: After a pass, the queue order from head to tail lists rank sets by first appearance. The set of the oldest command's rank comes first, then the set of the rank of the oldest command not already placed, and so on.
- R6: After a pass, the commands within each rank set keep their arrival order. Read flag and address travel with the command.
- R7: After a pass, each rank with at least one stored command has `set_vld` = 1. Its `set_end` equals the slot index just past its last command, with slot 0 at the head. Ranks with no command have `set_vld` = 0.
- R8: For every rank:
  - `set_reads` counts the stored commands with read flag 1 (flag 1 = read, 0 = write).
  - `set_writes` counts those with read flag 0.
  - `set_total` is their sum.
  - The counts follow every enqueue and dequeue.
- R9: Each dequeue shifts the queue by one slot and lowers every valid nonzero `set_end` by one.
- R10: An accepted enqueue clears all `set_vld` bits, as does an accepted strobe.
- R11: While `clus_start` is 1 in IDLE, `enq_ready` and `deq_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_ready | output | 1 | Enqueue accepted this cycle when high with enq_valid |
| enq_rank | input | RW | Target rank of the new command |
| enq_rd | input | 1 | 1 = read, 0 = write |
| enq_addr | input | ADDR_W | Command address |
| clus_start | input | 1 | Strobe that starts a regrouping pass |
| clus_done | output | 1 | One-cycle pass completion |
| deq_valid | output | 1 | Head command available |
| deq_pop | input | 1 | Remove the head command |
| deq_rank | output | RW | Rank of the head command |
| deq_rd | output | 1 | Read flag of the head command |
| deq_addr | output | ADDR_W | Address of the head command |
| set_vld | output | RANKS | Per-rank set boundary valid |
| set_end | output | RANKS x CW | Per-rank exclusive set end slot |
| set_total | output | RANKS x CW | Per-rank command count |
| set_reads | output | RANKS x CW | Per-rank read count |
| set_writes | output | RANKS x CW | Per-rank write count |

## Verification
The regrouping pass is swept over every fill level from empty to full, with several rank patterns:
- Pseudo-random ranks, which mix first-appearance order with interleaving.
- All commands to one rank, where the pass must leave the order untouched.
- A strict round-robin over the ranks, which forces the maximum number of insertions and marker shifts.
- Pairwise alternation, which exercises insertion with only two live markers.

Read flags and addresses are randomised so that in-set order errors show up as data mismatches. Each pattern also checks the done latency, the stall window, a strobe repeated during the pass, the marker decrement on pop, and the clearing of markers by a fresh enqueue.

// File: rtl/rcq_pkg.sv
package rcq_pkg;

    typedef enum logic [1:0] {
        RCQ_IDLE = 2'd0,
        RCQ_SCAN = 2'd1,
        RCQ_DONE = 2'd2
    } rcq_state_e;

endpackage

// File: rtl/rcq_store.sv
module rcq_store #(
    parameter int DEPTH = 16,
    parameter int EW    = 11,
    parameter int CW    = 5,
    parameter int IW    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [EW-1:0]             push_data,
    input  logic                      pop,
    input  logic                      ins,
    input  logic [IW-1:0]             ins_src,
    input  logic [IW-1:0]             ins_dst,
    output logic [DEPTH-1:0][EW-1:0]  slots,
    output logic [CW-1:0]             count
);

    logic [DEPTH-1:0][EW-1:0] slots_nxt;
    logic [CW-1:0]            count_nxt;
    logic [CW-1:0]            wr_idx;

    assign wr_idx = pop ? (count - CW'(1)) : count;

    always_comb begin
        count_nxt = count;
        if (!ins) begin
            if (pop) begin
                count_nxt = count_nxt - CW'(1);
            end
            if (push) begin
                count_nxt = count_nxt + CW'(1);
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [EW-1:0] from_below;
        logic [EW-1:0] from_above;

        if (g > 0) begin : g_lo
            assign from_below = slots[g-1];
        end else begin : g_lo0
            assign from_below = '0;
        end

        if (g < DEPTH-1) begin : g_hi
            assign from_above = slots[g+1];
        end else begin : g_hi0
            assign from_above = '0;
        end

        always_comb begin
            slots_nxt[g] = slots[g];
            if (ins) begin
                if (ins_dst == IW'(g)) begin
                    slots_nxt[g] = slots[ins_src];
                end else if ((IW'(g) > ins_dst) && (IW'(g) <= ins_src)) begin
                    slots_nxt[g] = from_below;
                end
            end else begin
                if (pop) begin
                    slots_nxt[g] = from_above;
                end
                if (push && (wr_idx == CW'(g))) begin
                    slots_nxt[g] = push_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots <= '0;
            count <= '0;
        end else begin
            slots <= slots_nxt;
            count <= count_nxt;
        end
    end

endmodule

// File: rtl/rcq_marks.sv
module rcq_marks #(
    parameter int RANKS = 4,
    parameter int RW    = 2,
    parameter int CW    = 5,
    parameter int IW    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       step,
    input  logic [RW-1:0]              step_rank,
    input  logic [IW-1:0]              step_slot,
    input  logic                       dec,
    output logic [RANKS-1:0]           vld,
    output logic [RANKS-1:0][CW-1:0]   mark,
    output logic                       ins,
    output logic [IW-1:0]              ins_dst
);

    logic          own_vld;
    logic [CW-1:0] own_mark;

    assign own_vld  = vld[step_rank];
    assign own_mark = mark[step_rank];
    assign ins      = step && own_vld;
    assign ins_dst  = own_mark[IW-1:0];

    for (genvar g = 0; g < RANKS; g++) begin : g_rank
        logic self_hit;
        assign self_hit = (step_rank == RW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g]  <= 1'b0;
                mark[g] <= '0;
            end else if (clr) begin
                vld[g]  <= 1'b0;
                mark[g] <= '0;
            end else if (step) begin
                if (self_hit) begin
                    if (!vld[g]) begin
                        vld[g]  <= 1'b1;
                        mark[g] <= CW'(step_slot) + CW'(1);
                    end else begin
                        mark[g] <= mark[g] + CW'(1);
                    end
                end else if (vld[g] && own_vld && (mark[g] > own_mark)) begin
                    mark[g] <= mark[g] + CW'(1);
                end
            end else if (dec && vld[g] && (mark[g] != '0)) begin
                mark[g] <= mark[g] - CW'(1);
            end
        end
    end

endmodule

// File: rtl/rcq_tally.sv
module rcq_tally #(
    parameter int RANKS = 4,
    parameter int RW    = 2,
    parameter int CW    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       add,
    input  logic [RW-1:0]              add_rank,
    input  logic                       add_rd,
    input  logic                       sub,
    input  logic [RW-1:0]              sub_rank,
    input  logic                       sub_rd,
    output logic [RANKS-1:0][CW-1:0]   reads,
    output logic [RANKS-1:0][CW-1:0]   writes
);

    for (genvar g = 0; g < RANKS; g++) begin : g_cnt
        logic add_hit;
        logic sub_hit;

        assign add_hit = add && (add_rank == RW'(g));
        assign sub_hit = sub && (sub_rank == RW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reads[g]  <= '0;
                writes[g] <= '0;
            end else begin
                reads[g]  <= reads[g]  + CW'(add_hit && add_rd)  - CW'(sub_hit && sub_rd);
                writes[g] <= writes[g] + CW'(add_hit && !add_rd) - CW'(sub_hit && !sub_rd);
            end
        end
    end

endmodule

// File: rtl/rank_cluster_rq.sv
module rank_cluster_rq #(
    parameter int DEPTH  = 16,
    parameter int RANKS  = 4,
    parameter int ADDR_W = 8,
    localparam int RW    = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enq_valid,
    output logic                      enq_ready,
    input  logic [RW-1:0]             enq_rank,
    input  logic                      enq_rd,
    input  logic [ADDR_W-1:0]         enq_addr,
    input  logic                      clus_start,
    output logic                      clus_done,
    output logic                      deq_valid,
    input  logic                      deq_pop,
    output logic [RW-1:0]             deq_rank,
    output logic                      deq_rd,
    output logic [ADDR_W-1:0]         deq_addr,
    output logic [RANKS-1:0]          set_vld,
    output logic [RANKS-1:0][CW-1:0]  set_end,
    output logic [RANKS-1:0][CW-1:0]  set_total,
    output logic [RANKS-1:0][CW-1:0]  set_reads,
    output logic [RANKS-1:0][CW-1:0]  set_writes
);

    import rcq_pkg::*;

    localparam int EW = RW + 1 + ADDR_W;

    rcq_state_e               state;
    rcq_state_e               state_nxt;
    logic [CW-1:0]            scan_idx;
    logic [DEPTH-1:0][EW-1:0] q_slots;
    logic [CW-1:0]            q_count;
    logic                     enq_fire;
    logic                     deq_fire;
    logic                     start_take;
    logic                     scan_step;
    logic [RW-1:0]            scan_rank;
    logic                     mv_ins;
    logic [IW-1:0]            mv_dst;
    logic [EW-1:0]            head;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RCQ_IDLE;
            scan_idx <= '0;
        end else begin
            state <= state_nxt;
            if (start_take) begin
                scan_idx <= '0;
            end else if (state == RCQ_SCAN) begin
                scan_idx <= scan_idx + CW'(1);
            end
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RCQ_IDLE: begin
                if (clus_start) begin
                    state_nxt = (q_count == '0) ? RCQ_DONE : RCQ_SCAN;
                end
            end
            RCQ_SCAN: begin
                if ((scan_idx + CW'(1)) == q_count) begin
                    state_nxt = RCQ_DONE;
                end
            end
            RCQ_DONE: begin
                state_nxt = RCQ_IDLE;
            end
            default: begin
                state_nxt = RCQ_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        enq_ready  = 1'b0;
        deq_valid  = 1'b0;
        clus_done  = 1'b0;
        start_take = 1'b0;
        scan_step  = 1'b0;
        unique case (state)
            RCQ_IDLE: begin
                start_take = clus_start;
                enq_ready  = !clus_start && (q_count < CW'(DEPTH));
                deq_valid  = !clus_start && (q_count != '0);
            end
            RCQ_SCAN: begin
                scan_step = 1'b1;
            end
            RCQ_DONE: begin
                clus_done = 1'b1;
            end
            default: begin
                clus_done = 1'b0;
            end
        endcase
    end

    assign enq_fire  = enq_valid && enq_ready;
    assign deq_fire  = deq_pop && deq_valid;
    assign scan_rank = q_slots[scan_idx[IW-1:0]][EW-1 -: RW];
    assign head      = q_slots[0];
    assign deq_rank  = head[EW-1 -: RW];
    assign deq_rd    = head[ADDR_W];
    assign deq_addr  = head[ADDR_W-1:0];

    rcq_store #(
        .DEPTH (DEPTH),
        .EW    (EW),
        .CW    (CW),
        .IW    (IW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enq_fire),
        .push_data ({enq_rank, enq_rd, enq_addr}),
        .pop       (deq_fire),
        .ins       (mv_ins),
        .ins_src   (scan_idx[IW-1:0]),
        .ins_dst   (mv_dst),
        .slots     (q_slots),
        .count     (q_count)
    );

    rcq_marks #(
        .RANKS (RANKS),
        .RW    (RW),
        .CW    (CW),
        .IW    (IW)
    ) u_marks (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_take || enq_fire),
        .step      (scan_step),
        .step_rank (scan_rank),
        .step_slot (scan_idx[IW-1:0]),
        .dec       (deq_fire),
        .vld       (set_vld),
        .mark      (set_end),
        .ins       (mv_ins),
        .ins_dst   (mv_dst)
    );

    rcq_tally #(
        .RANKS (RANKS),
        .RW    (RW),
        .CW    (CW)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .add      (enq_fire),
        .add_rank (enq_rank),
        .add_rd   (enq_rd),
        .sub      (deq_fire),
        .sub_rank (deq_rank),
        .sub_rd   (deq_rd),
        .reads    (set_reads),
        .writes   (set_writes)
    );

    for (genvar g = 0; g < RANKS; g++) begin : g_total
        assign set_total[g] = set_reads[g] + set_writes[g];
    end

endmodule

// File: rtl/rcq_chk.sv
module rcq_chk #(
    parameter int DEPTH = 16,
    parameter int RANKS = 4,
    parameter int CW    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  rcq_pkg::rcq_state_e        state,
    input  logic [CW-1:0]              scan_idx,
    input  logic [CW-1:0]              q_count,
    input  logic                       enq_valid,
    input  logic                       enq_ready,
    input  logic                       deq_valid,
    input  logic                       deq_pop,
    input  logic                       clus_done,
    input  logic [RANKS-1:0]           set_vld,
    input  logic [RANKS-1:0][CW-1:0]   set_end,
    input  logic [RANKS-1:0][CW-1:0]   set_total
);

    import rcq_pkg::*;

    logic [CW+3:0] total_sum;

    always_comb begin
        total_sum = '0;
        for (int k = 0; k < RANKS; k++) begin
            total_sum = total_sum + (CW+4)'(set_total[k]);
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clus_done |=> !clus_done);

    // R3
    scan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RCQ_SCAN) |-> (scan_idx < q_count));

    // R4
    busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RCQ_IDLE) |-> (!enq_ready && !deq_valid));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CW'(DEPTH)) |-> !enq_ready);

    // R8
    tally_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total_sum == (CW+4)'(q_count));

    // R10
    enq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_ready) |=> (set_vld == '0));

    for (genvar g = 0; g < RANKS; g++) begin : g_rank_chk
        // R7
        end_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vld[g] |-> (set_end[g] <= q_count));

        // R9
        pop_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (deq_pop && deq_valid && set_vld[g] && (set_end[g] != '0))
            |=> (set_end[g] == ($past(set_end[g]) - CW'(1))));
    end

endmodule

bind rank_cluster_rq rcq_chk #(
    .DEPTH (DEPTH),
    .RANKS (RANKS),
    .CW    (CW)
) u_rcq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .scan_idx  (scan_idx),
    .q_count   (q_count),
    .enq_valid (enq_valid),
    .enq_ready (enq_ready),
    .deq_valid (deq_valid),
    .deq_pop   (deq_pop),
    .clus_done (clus_done),
    .set_vld   (set_vld),
    .set_end   (set_end),
    .set_total (set_total)
);

// File: tb/test_rank_cluster_rq.sv
`timescale 1ns/1ps
module test_rank_cluster_rq;

    localparam int DEPTH  = 8;
    localparam int RANKS  = 4;
    localparam int ADDR_W = 4;
    localparam int RW     = 2;
    localparam int CW     = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     enq_valid = 1'b0;
    logic                     enq_ready;
    logic [RW-1:0]            enq_rank = '0;
    logic                     enq_rd = 1'b0;
    logic [ADDR_W-1:0]        enq_addr = '0;
    logic                     clus_start = 1'b0;
    logic                     clus_done;
    logic                     deq_valid;
    logic                     deq_pop = 1'b0;
    logic [RW-1:0]            deq_rank;
    logic                     deq_rd;
    logic [ADDR_W-1:0]        deq_addr;
    logic [RANKS-1:0]         set_vld;
    logic [RANKS-1:0][CW-1:0] set_end;
    logic [RANKS-1:0][CW-1:0] set_total;
    logic [RANKS-1:0][CW-1:0] set_reads;
    logic [RANKS-1:0][CW-1:0] set_writes;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    int in_r[DEPTH+1];
    int in_d[DEPTH+1];
    int in_a[DEPTH+1];
    int ex_r[DEPTH+1];
    int ex_d[DEPTH+1];
    int ex_a[DEPTH+1];
    int ex_end[RANKS];
    int ex_vld[RANKS];
    int ex_rd[RANKS];
    int ex_wr[RANKS];
    logic [15:0] lf = 16'hACE1;

    rank_cluster_rq #(
        .DEPTH  (DEPTH),
        .RANKS  (RANKS),
        .ADDR_W (ADDR_W)
    ) i_rank_cluster_rq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_valid  (enq_valid),
        .enq_ready  (enq_ready),
        .enq_rank   (enq_rank),
        .enq_rd     (enq_rd),
        .enq_addr   (enq_addr),
        .clus_start (clus_start),
        .clus_done  (clus_done),
        .deq_valid  (deq_valid),
        .deq_pop    (deq_pop),
        .deq_rank   (deq_rank),
        .deq_rd     (deq_rd),
        .deq_addr   (deq_addr),
        .set_vld    (set_vld),
        .set_end    (set_end),
        .set_total  (set_total),
        .set_reads  (set_reads),
        .set_writes (set_writes)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int m);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return int'(lf) % m;
    endfunction

    task automatic build_expected(input int n);
        int pos = 0;
        bit seen[RANKS];
        for (int r = 0; r < RANKS; r++) begin
            seen[r] = 0;
            ex_end[r] = 0;
            ex_vld[r] = 0;
        end
        for (int i = 0; i < n; i++) begin
            int r = in_r[i];
            if (!seen[r]) begin
                seen[r] = 1;
                for (int j = i; j < n; j++) begin
                    if (in_r[j] == r) begin
                        ex_r[pos] = in_r[j];
                        ex_d[pos] = in_d[j];
                        ex_a[pos] = in_a[j];
                        pos++;
                    end
                end
                ex_end[r] = pos;
                ex_vld[r] = 1;
            end
        end
    endtask

    task automatic enq(input int r, input int d, input int a, input string req);
        @(negedge clk);
        chk(enq_ready == 1'b1, req, int'(enq_ready), 1);
        enq_valid = 1'b1;
        enq_rank  = RW'(r);
        enq_rd    = d[0];
        enq_addr  = ADDR_W'(a);
        @(posedge clk);
        #1;
        enq_valid = 1'b0;
    endtask

    task automatic deq_expect(input int r, input int d, input int a);
        @(negedge clk);
        chk(deq_valid == 1'b1, "R9 deq_valid", int'(deq_valid), 1);
        chk(int'(deq_rank) == r, "R5 set order rank", int'(deq_rank), r);
        chk(int'(deq_rd) == d && int'(deq_addr) == a, "R6 in-set order",
            int'(deq_addr) + 16 * int'(deq_rd), a + 16 * d);
        deq_pop = 1'b1;
        @(posedge clk);
        #1;
        deq_pop = 1'b0;
    endtask

    task automatic check_counts(input string req);
        @(negedge clk);
        for (int r = 0; r < RANKS; r++) begin
            chk(int'(set_reads[r]) == ex_rd[r], req, int'(set_reads[r]), ex_rd[r]);
            chk(int'(set_writes[r]) == ex_wr[r], req, int'(set_writes[r]), ex_wr[r]);
            chk(int'(set_total[r]) == ex_rd[r] + ex_wr[r], req, int'(set_total[r]),
                ex_rd[r] + ex_wr[r]);
        end
    endtask

    task automatic run_pass(input int n, input bit repulse);
        int exp_c = (n == 0) ? 1 : n + 1;
        int dc = 0;
        int dn = 0;
        @(negedge clk);
        clus_start = 1'b1;
        #1;
        chk(enq_ready == 1'b0 && deq_valid == 1'b0, "R11 strobe blocks ports",
            int'(enq_ready) + int'(deq_valid), 0);
        @(posedge clk);
        #1;
        clus_start = 1'b0;
        for (int c = 1; c <= n + 3; c++) begin
            @(negedge clk);
            if (clus_done) begin
                dn++;
                if (dc == 0) dc = c;
            end
            if (c <= exp_c) begin
                chk(enq_ready == 1'b0 && deq_valid == 1'b0, "R4 stall during pass",
                    int'(enq_ready) + int'(deq_valid), 0);
            end
            clus_start = (repulse && c == 2) ? 1'b1 : 1'b0;
        end
        clus_start = 1'b0;
        chk(dc == exp_c, "R3 done latency", dc, exp_c);
        chk(dn == 1, "R3 done single pulse", dn, 1);
        chk(enq_ready == (n < DEPTH), "R4 back to idle", int'(enq_ready), int'(n < DEPTH));
    endtask

    task automatic round(input int n, input int mode, input bit repulse, input bit extra);
        for (int r = 0; r < RANKS; r++) begin
            ex_rd[r] = 0;
            ex_wr[r] = 0;
        end
        for (int i = 0; i < n; i++) begin
            case (mode)
                0: in_r[i] = rnd(RANKS);
                1: in_r[i] = 2;
                2: in_r[i] = (RANKS - 1) - (i % RANKS);
                default: in_r[i] = (i % 2 == 0) ? 1 : 3;
            endcase
            in_d[i] = rnd(2);
            in_a[i] = rnd(16);
            if (in_d[i] != 0) ex_rd[in_r[i]]++;
            else ex_wr[in_r[i]]++;
            enq(in_r[i], in_d[i], in_a[i], "R2 enqueue accepted");
        end
        check_counts("R8 counts before pass");
        build_expected(n);
        run_pass(n, repulse);
        @(negedge clk);
        for (int r = 0; r < RANKS; r++) begin
            chk(int'(set_vld[r]) == ex_vld[r], "R7 set valid", int'(set_vld[r]), ex_vld[r]);
            if (ex_vld[r] != 0) begin
                chk(int'(set_end[r]) == ex_end[r], "R7 set end", int'(set_end[r]), ex_end[r]);
            end
        end
        check_counts("R8 counts after pass");
        if (extra && n < DEPTH) begin
            ex_r[n] = 0;
            ex_d[n] = 1;
            ex_a[n] = 5;
            ex_rd[0]++;
            enq(0, 1, 5, "R10 enqueue after pass");
            @(negedge clk);
            chk(set_vld == '0, "R10 markers cleared", int'(set_vld), 0);
            check_counts("R8 counts after extra");
            n = n + 1;
        end
        for (int i = 0; i < n; i++) begin
            deq_expect(ex_r[i], ex_d[i], ex_a[i]);
            if (i == 0 && !extra) begin
                @(negedge clk);
                for (int r = 0; r < RANKS; r++) begin
                    if (ex_vld[r] != 0) begin
                        int e = (ex_end[r] > 0) ? ex_end[r] - 1 : 0;
                        chk(int'(set_end[r]) == e, "R9 marker follows pop", int'(set_end[r]), e);
                    end
                end
            end
        end
        @(negedge clk);
        chk(deq_valid == 1'b0, "R9 queue drained", int'(deq_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(enq_ready == 1'b1, "R1 enq_ready", int'(enq_ready), 1);
        chk(deq_valid == 1'b0, "R1 deq_valid", int'(deq_valid), 0);
        chk(clus_done == 1'b0, "R1 done", int'(clus_done), 0);
        chk(set_vld == '0, "R1 set_vld", int'(set_vld), 0);
        chk(set_total == '0, "R1 totals", int'(set_total), 0);

        // R2 plain FIFO behaviour and full stall
        for (int i = 0; i < DEPTH; i++) begin
            enq(i % RANKS, i % 2, (i * 3) % 16, "R2 fill");
        end
        @(negedge clk);
        chk(enq_ready == 1'b0, "R2 full blocks enqueue", int'(enq_ready), 0);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            chk(int'(deq_addr) == (i * 3) % 16 && int'(deq_rank) == i % RANKS,
                "R2 fifo order", int'(deq_addr), (i * 3) % 16);
            deq_pop = 1'b1;
            @(posedge clk);
            #1;
            deq_pop = 1'b0;
        end

        // sweeps over fill level and rank pattern
        for (int mode = 0; mode < 4; mode++) begin
            for (int n = 0; n <= DEPTH; n++) begin
                round(n, mode, (n >= 3), 1'b0);
                round(n, mode, 1'b0, (n % 3 == 1));
            end
        end
        for (int k = 0; k < 20; k++) begin
            round(DEPTH - (k % 3), 0, 1'b0, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule